// File: doc/BRIEF.md
# Bus Clock and Frame Loss Monitor

This block supervises an external cell bus from inside a local processor-clock domain. It samples three bus signals: the frame pulse, the read clock and the write clock. A missing frame pulse is detected by counting programmable-length frame periods that pass without a pulse. A stopped bus clock is detected by a per-clock watchdog that counts local cycles since the last edge seen on that clock. Each loss event sets a sticky status bit.

The same status byte also holds sticky flags for three single-cycle strobes that come from elsewhere in the chip:

- a receive parity (BIP-8) error;
- a control cell that was accepted at its destination;
- a control cell that was refused.

An interrupt-enable byte masks these flags onto a single interrupt line. A small register port reads and writes both bytes. Reading the status byte clears it. The port also carries a self-clearing command bit that sends a one-cycle clear pulse to counters outside the block.

Top module: `bus_loss_monitor`

## Requirements
- R1: With `fourFrameMode` low, a frame-loss event (status bit 2) is raised once two consecutive frame periods of `frameLen` local cycles pass with no frame pulse. With `fourFrameMode` high, four periods are needed. Each detected frame pulse resets the missed-period count to zero.
- R2: Status bit 1 is set when the synchronized read clock shows no edge for more than 32 local clock cycles. It stays clear while the read clock keeps toggling.
- R3: Status bit 0 applies the same 32-cycle rule to the write clock, independently of the read clock.
- R4: The register map uses address 0 for status, address 1 for interrupt enable and address 2 for the command. The status layout is fixed. Bit 7 is a refused control cell, bit 6 an accepted control cell, bit 3 a BIP-8 error, bit 2 frame loss, bit 1 read-clock loss and bit 0 write-clock loss. Bits 5 and 4 always read 0.
- R5: `irqOut` is high exactly when some status bit is 1 and the enable bit at the same position is 1.
- R6: A status bit, once set by its event, stays set after the event ends until the status byte is read.
- R7: A read of address 0 returns the current status and clears it on the following clock edge. An event that arrives in the same cycle as that read leaves its bit set.
- R8: Writing 1 to bit 0 of address 2 drives `ctrClear` high for exactly one local cycle. Address 2 bit 0 reads 0 from the next cycle on. Writing 0 there produces no pulse.
- R9: The enable byte reads back what was written, with bits 5 and 4 forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local processor clock |
| rstN | input | 1 | Active-low synchronous reset |
| busFramePulse | input | 1 | Bus frame pulse (asynchronous) |
| busReadClk | input | 1 | Bus read clock (asynchronous) |
| busWriteClk | input | 1 | Bus write clock (asynchronous) |
| fourFrameMode | input | 1 | Strap: 0 = two missed periods, 1 = four |
| frameLen | input | LEN_W | Expected frame period in local cycles |
| bipErrStb | input | 1 | One-cycle BIP-8 error strobe |
| ctlAckStb | input | 1 | One-cycle control-cell accepted strobe |
| ctlNakStb | input | 1 | One-cycle control-cell refused strobe |
| regAddr | input | 2 | Register address |
| regWr | input | 1 | Register write enable |
| regRd | input | 1 | Register read enable |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, combinational on `regAddr` |
| irqOut | output | 1 | Masked interrupt |
| ctrClear | output | 1 | One-cycle clear pulse to external counters |

## Verification
The assertions assume that each event strobe is high for a single cycle and that `regWr` and `regRd` are never high together. They also assume the bus clocks run slowly enough, compared with `clk`, that the two-flop synchronizer sees every level, and that `frameLen` is nonzero and constant during a test. The stimulus follows these assumptions:

- both bus clocks toggle every four local cycles;
- frame pulses are one local cycle wide and arrive every 20 cycles;
- `frameLen` is held at 20;
- every register access is a single-cycle read or write, driven on the falling edge.

// File: rtl/busmon_pkg.sv
package busmon_pkg;
  localparam int STAT_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int BIT_WRCK = 0;
  localparam int BIT_RDCK = 1;
  localparam int BIT_FRM  = 2;
  localparam int BIT_BIP  = 3;
  localparam int BIT_ACK  = 6;
  localparam int BIT_NAK  = 7;
  localparam logic [STAT_W-1:0] LIVE_MASK = 8'hCF;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMD    = 2'd2;

  typedef struct packed {
    logic              statusRead;
    logic              enableWrite;
    logic              clearCmd;
    logic [STAT_W-1:0] wrData;
  } ctrlStrobes_t;
endpackage

// File: rtl/clk_watchdog.sv
module clk_watchdog #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic busClk,
  output logic lossEvt
);
  localparam int CNT_W = $clog2(LIMIT + 2);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(LIMIT + 1);

  logic syncA, syncB, syncC;
  logic edgeSeen;
  logic [CNT_W-1:0] idleCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncC <= 1'b0;
    end else begin
      syncA <= busClk;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign edgeSeen = syncB ^ syncC;

  always_ff @(posedge clk) begin
    if (!rstN)               idleCnt <= '0;
    else if (edgeSeen)       idleCnt <= '0;
    else if (idleCnt != SAT_V) idleCnt <= idleCnt + 1'b1;
  end

  assign lossEvt = !edgeSeen && (idleCnt == LIM_V);

  AST_WDOG_SINGLE_EVT: assert property (@(posedge clk) disable iff (!rstN)
    lossEvt |=> !lossEvt); // R2
  AST_WDOG_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    edgeSeen |=> !lossEvt); // R3
endmodule

// File: rtl/frame_loss_detect.sv
module frame_loss_detect #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             framePulse,
  input  logic             fourMode,
  input  logic [LEN_W-1:0] frameLen,
  output logic             lossEvt
);
  logic syncA, syncB, syncC;
  logic pulseSeen;
  logic periodWrap;
  logic [LEN_W-1:0] periodCnt;
  logic [2:0] missCnt;
  logic [2:0] missLimit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncC <= 1'b0;
    end else begin
      syncA <= framePulse;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign pulseSeen  = syncB & ~syncC;
  assign periodWrap = (periodCnt == frameLen - LEN_W'(1));
  assign missLimit  = fourMode ? 3'd4 : 3'd2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodCnt <= '0;
      missCnt   <= '0;
    end else if (pulseSeen) begin
      periodCnt <= '0;
      missCnt   <= '0;
    end else if (periodWrap) begin
      periodCnt <= '0;
      if (missCnt < 3'd4) missCnt <= missCnt + 3'd1;
    end else begin
      periodCnt <= periodCnt + 1'b1;
    end
  end

  assign lossEvt = !pulseSeen && periodWrap && (missCnt + 3'd1 == missLimit);

  AST_FRM_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    pulseSeen |=> !lossEvt); // R1
  AST_FRM_SINGLE_EVT: assert property (@(posedge clk) disable iff (!rstN)
    (lossEvt && $stable(fourMode)) |=> !lossEvt); // R1
endmodule

// File: rtl/monitor_ctrl.sv
module monitor_ctrl
  import busmon_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [STAT_W-1:0] regWdata,
  input  logic [STAT_W-1:0] statusQ,
  input  logic [STAT_W-1:0] enableQ,
  input  logic              clearQ,
  output ctrlStrobes_t      strobes,
  output logic [STAT_W-1:0] regRdata
);
  always_comb begin
    strobes.statusRead  = regRd && (regAddr == ADDR_STATUS);
    strobes.enableWrite = regWr && (regAddr == ADDR_ENABLE);
    strobes.clearCmd    = regWr && (regAddr == ADDR_CMD) && regWdata[0];
    strobes.wrData      = regWdata;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_STATUS: regRdata = statusQ;
      ADDR_ENABLE: regRdata = enableQ;
      ADDR_CMD:    regRdata = {{(STAT_W-1){1'b0}}, clearQ};
      default:     regRdata = '0;
    endcase
  end

  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRd |-> (regRdata[5:4] == 2'b00)); // R4
  AST_NO_CMD_ON_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_CMD && !regWdata[0]) |-> !strobes.clearCmd); // R8
endmodule

// File: rtl/monitor_datapath.sv
module monitor_datapath
  import busmon_pkg::*;
#(
  parameter int CLK_LIMIT = 32,
  parameter int LEN_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busFramePulse,
  input  logic              busReadClk,
  input  logic              busWriteClk,
  input  logic              fourFrameMode,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic              bipErrStb,
  input  logic              ctlAckStb,
  input  logic              ctlNakStb,
  input  ctrlStrobes_t      strobes,
  output logic [STAT_W-1:0] statusQ,
  output logic [STAT_W-1:0] enableQ,
  output logic              clearQ
);
  localparam int N_CLK = 2;

  logic [N_CLK-1:0]  busClks;
  logic [N_CLK-1:0]  clkLoss;
  logic              frameLoss;
  logic [STAT_W-1:0] evtVec;

  assign busClks = {busReadClk, busWriteClk};

  for (genvar g = 0; g < N_CLK; g++) begin : gWdog
    clk_watchdog #(.LIMIT(CLK_LIMIT)) uWdog (
      .clk     (clk),
      .rstN    (rstN),
      .busClk  (busClks[g]),
      .lossEvt (clkLoss[g])
    );
  end

  frame_loss_detect #(.LEN_W(LEN_W)) uFrame (
    .clk        (clk),
    .rstN       (rstN),
    .framePulse (busFramePulse),
    .fourMode   (fourFrameMode),
    .frameLen   (frameLen),
    .lossEvt    (frameLoss)
  );

  always_comb begin
    evtVec           = '0;
    evtVec[BIT_WRCK] = clkLoss[0];
    evtVec[BIT_RDCK] = clkLoss[1];
    evtVec[BIT_FRM]  = frameLoss;
    evtVec[BIT_BIP]  = bipErrStb;
    evtVec[BIT_ACK]  = ctlAckStb;
    evtVec[BIT_NAK]  = ctlNakStb;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
      clearQ  <= 1'b0;
    end else begin
      statusQ <= ((statusQ & ~{STAT_W{strobes.statusRead}}) | evtVec) & LIVE_MASK;
      if (strobes.enableWrite) enableQ <= strobes.wrData & LIVE_MASK;
      clearQ <= strobes.clearCmd;
    end
  end

  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.statusRead |=> ((statusQ & $past(statusQ)) == $past(statusQ))); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.statusRead |=> ((statusQ & ~$past(evtVec)) == '0)); // R7
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.statusRead && bipErrStb) |=> statusQ[BIT_BIP]); // R7
  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    clearQ |=> !clearQ); // R8
endmodule

// File: rtl/bus_loss_monitor.sv
module bus_loss_monitor
  import busmon_pkg::*;
#(
  parameter int CLK_LIMIT = 32,
  parameter int LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busFramePulse,
  input  logic             busReadClk,
  input  logic             busWriteClk,
  input  logic             fourFrameMode,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             bipErrStb,
  input  logic             ctlAckStb,
  input  logic             ctlNakStb,
  input  logic [1:0]       regAddr,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  output logic             irqOut,
  output logic             ctrClear
);
  ctrlStrobes_t      strobes;
  logic [STAT_W-1:0] statusQ;
  logic [STAT_W-1:0] enableQ;
  logic              clearQ;

  monitor_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWr    (regWr),
    .regRd    (regRd),
    .regWdata (regWdata),
    .statusQ  (statusQ),
    .enableQ  (enableQ),
    .clearQ   (clearQ),
    .strobes  (strobes),
    .regRdata (regRdata)
  );

  monitor_datapath #(.CLK_LIMIT(CLK_LIMIT), .LEN_W(LEN_W)) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .busFramePulse (busFramePulse),
    .busReadClk    (busReadClk),
    .busWriteClk   (busWriteClk),
    .fourFrameMode (fourFrameMode),
    .frameLen      (frameLen),
    .bipErrStb     (bipErrStb),
    .ctlAckStb     (ctlAckStb),
    .ctlNakStb     (ctlNakStb),
    .strobes       (strobes),
    .statusQ       (statusQ),
    .enableQ       (enableQ),
    .clearQ        (clearQ)
  );

  assign irqOut   = |(statusQ & enableQ);
  assign ctrClear = clearQ;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ == '0) |-> !irqOut); // R5
endmodule

// File: tb/tb_bus_loss_monitor.sv
module tb_bus_loss_monitor;
  localparam int LEN_W = 16;
  localparam int FLEN  = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busFramePulse = 1'b0, busReadClk = 1'b0, busWriteClk = 1'b0;
  logic fourFrameMode = 1'b0;
  logic [LEN_W-1:0] frameLen = LEN_W'(FLEN);
  logic bipErrStb = 1'b0, ctlAckStb = 1'b0, ctlNakStb = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic irqOut, ctrClear;

  int nRun = 0, nFail = 0, cyc = 0;
  logic rdRun = 1'b1, wrRun = 1'b1, frmRun = 1'b1, pulseReq = 1'b0;
  int ph = 0, fc = 0;
  logic [7:0] v;

  bus_loss_monitor #(.CLK_LIMIT(32), .LEN_W(LEN_W)) dut (
    .clk(clk), .rstN(rstN), .busFramePulse(busFramePulse),
    .busReadClk(busReadClk), .busWriteClk(busWriteClk),
    .fourFrameMode(fourFrameMode), .frameLen(frameLen),
    .bipErrStb(bipErrStb), .ctlAckStb(ctlAckStb), .ctlNakStb(ctlNakStb),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut), .ctrClear(ctrClear)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nRun++; nFail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  always @(negedge clk) begin
    ph <= (ph + 1) % 4;
    if (ph == 0) begin
      if (rdRun) busReadClk  <= ~busReadClk;
      if (wrRun) busWriteClk <= ~busWriteClk;
    end
    if (frmRun) begin
      busFramePulse <= (fc == 0);
      fc <= (fc == FLEN - 1) ? 0 : fc + 1;
    end else begin
      busFramePulse <= pulseReq;
      fc <= 0;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRd = 1'b1; #1 d = regRdata;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic stopFrameAfterPulse();
    do @(negedge clk); while (!busFramePulse);
    frmRun = 1'b0;
  endtask

  // enable write value, expected readback
  localparam logic [15:0] ENA_VEC [6] = '{
    {8'hFF, 8'hCF}, {8'h30, 8'h00}, {8'h81, 8'h81},
    {8'h4C, 8'h4C}, {8'hB6, 8'h86}, {8'h00, 8'h00}
  };

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    #1 check("R5 reset irq", {7'b0, irqOut}, 8'h00);
    regRead(2'd0, v); check("R4 reset status", v, 8'h00);
    regRead(2'd1, v); check("R9 reset enable", v, 8'h00);

    // R9 enable register vectors
    foreach (ENA_VEC[i]) begin
      regWrite(2'd1, ENA_VEC[i][15:8]);
      regRead(2'd1, v);
      check("R9 enable readback", v, ENA_VEC[i][7:0]);
      check("R5 irq with empty status", {7'b0, irqOut}, 8'h00);
    end

    // R6 sticky strobes, R4 bit positions
    bipErrStb = 1'b1; @(negedge clk); bipErrStb = 1'b0;
    ctlAckStb = 1'b1; @(negedge clk); ctlAckStb = 1'b0;
    waitCyc(10);
    regRead(2'd0, v); check("R6 R4 sticky bip+ack", v, 8'h48);
    regRead(2'd0, v); check("R7 clear on read", v, 8'h00);
    ctlNakStb = 1'b1; @(negedge clk); ctlNakStb = 1'b0;
    regRead(2'd0, v); check("R4 nak bit7", v, 8'h80);

    // R5 irq masking
    regWrite(2'd1, 8'h08);
    bipErrStb = 1'b1; @(negedge clk); bipErrStb = 1'b0;
    #1 check("R5 irq enabled bit", {7'b0, irqOut}, 8'h01);
    regWrite(2'd1, 8'h40);
    #1 check("R5 irq masked bit", {7'b0, irqOut}, 8'h00);
    regRead(2'd0, v); check("R6 status kept while masked", v, 8'h08);
    regWrite(2'd1, 8'h00);

    // R7 event in same cycle as read wins
    @(negedge clk); bipErrStb = 1'b1; regAddr = 2'd0; regRd = 1'b1; #1 v = regRdata;
    check("R7 read before event", v, 8'h00);
    @(negedge clk); bipErrStb = 1'b0; regRd = 1'b0;
    regRead(2'd0, v); check("R7 same-cycle event wins", v, 8'h08);

    // R8 counter clear
    regWrite(2'd2, 8'h00);
    #1 check("R8 no pulse on zero", {7'b0, ctrClear}, 8'h00);
    @(negedge clk); regAddr = 2'd2; regWdata = 8'h01; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0; #1 check("R8 pulse high", {7'b0, ctrClear}, 8'h01);
    @(negedge clk); #1 check("R8 pulse one cycle", {7'b0, ctrClear}, 8'h00);
    regRead(2'd2, v); check("R8 cmd reads zero", v, 8'h00);

    // R2 read-clock loss
    regRead(2'd0, v);
    rdRun = 1'b0;
    waitCyc(20);
    regRead(2'd0, v); check("R2 no loss at 20 idle", v & 8'h02, 8'h00);
    waitCyc(25);
    regRead(2'd0, v); check("R2 read loss set, R3 write clear", v & 8'h03, 8'h02);
    rdRun = 1'b1; waitCyc(10);
    regRead(2'd0, v);
    waitCyc(80);
    regRead(2'd0, v); check("R2 running clock no loss", v & 8'h03, 8'h00);

    // R3 write-clock loss
    wrRun = 1'b0;
    waitCyc(45);
    regRead(2'd0, v); check("R3 write loss independent", v & 8'h03, 8'h01);
    wrRun = 1'b1; waitCyc(10);
    regRead(2'd0, v);

    // R1 two-frame mode
    fourFrameMode = 1'b0; waitCyc(3 * FLEN);
    regRead(2'd0, v); check("R1 frames present", v & 8'h04, 8'h00);
    stopFrameAfterPulse();
    waitCyc(30);
    regRead(2'd0, v); check("R1 1.5 frames missing", v & 8'h04, 8'h00);
    pulseReq = 1'b1; @(negedge clk); pulseReq = 1'b0;
    waitCyc(30);
    regRead(2'd0, v); check("R1 pulse resets miss count", v & 8'h04, 8'h00);
    waitCyc(20);
    regRead(2'd0, v); check("R1 two frames missing", v & 8'h04, 8'h04);

    // R1 four-frame mode
    frmRun = 1'b1; fourFrameMode = 1'b1; waitCyc(3 * FLEN);
    regRead(2'd0, v);
    stopFrameAfterPulse();
    waitCyc(62);
    regRead(2'd0, v); check("R1 four mode, 3 frames missing", v & 8'h04, 8'h00);
    waitCyc(30);
    regRead(2'd0, v); check("R1 four mode, 4 frames missing", v & 8'h04, 8'h04);
    frmRun = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule